// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit sits beside the serial engines of a UART-style port. It is the part of the port that faces the modem lines. A small register port lets software write a control register that drives two general-purpose active-low outputs and a loop-mode indication. The same port gives access to a one-bit modem-status interrupt enable and a read-only modem status register.

Four active-low modem inputs are brought in through a synchronizer. These are clear-to-send, data-set-ready, ring indicator and carrier detect. The status register shows the live, active-high state of each input. For each input it also holds a sticky change flag. The ring-indicator flag captures only the end of a ring pulse, which is the pin going from low to high. The other three flags capture any change. Reading the status register clears the flags. When the interrupt is enabled, any set flag raises the modem-status interrupt.

The loop-mode indication is passed on to the shift engines, which are outside this unit. While loop mode is on, both general outputs are held inactive. The carrier-detect input only affects the status register and the interrupt. It plays no part in receive data handling.

Top module: `mdm_ctrl_stat`

## Requirements
- R1: While `rst` is high and after it is released, the control register, the enable bit and all change flags are 0, both general outputs are high, `loop_mode` is 0 and `modem_irq` is 0.
- R2: Register address 0 is the control register. Its bits 4:0 are writable and read back, and bits 7:5 read 0. Control bit 2 at 1 drives `gpo1_n` low. Control bit 3 at 1 drives `gpo2_n` low. The outputs change on the clock edge that takes the write.
- R3: Control bit 4 is loop mode. It drives `loop_mode` high and holds `gpo1_n` and `gpo2_n` high, whatever bits 2 and 3 hold.
- R4: Address 1 reads the status register. Bits 4, 5, 6 and 7 are the present states of clear-to-send, data-set-ready, ring indicator and carrier detect. Each reads 1 when its pin is low. A pin change first shows there on the second clock edge after it, because of the two-flop synchronizer.
- R5: Status bit 2 is set only when the ring pin goes from low to high, on the third clock edge after that change. A high-to-low change leaves it unchanged.
- R6: Status bits 0, 1 and 3 are set on any change of clear-to-send, data-set-ready and carrier detect respectively, on the third clock edge after the pin change. Once set, they stay set until cleared.
- R7: Address 2 holds the modem-status interrupt enable in bit 3, and its other bits read 0. `modem_irq` is high exactly when that bit is 1 and any of status bits 3:0 is 1. It drops once those bits are cleared.
- R8: A read of address 1 (`rd_en` high with `addr` = 1) clears status bits 3:0 at that clock edge. A change flag that is set by the same edge is kept.
- R9: Writes to address 1 and reads or writes of address 3 have no effect on any register. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears change flags when reading status) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| gpo1_n | output | 1 | General output 1, active low |
| gpo2_n | output | 1 | General output 2, active low |
| loop_mode | output | 1 | Loop-mode indication to the shift engines |
| modem_irq | output | 1 | Modem-status interrupt request, active high |

## Verification
Register writes show on the outputs at the edge that takes them. A pin change shows in the present-state bits two edges later and in a change flag three edges later. A flag cleared by a read is gone after that edge, and the interrupt follows the flags with no extra delay. The bench keeps a queue of pin samples taken at each rising edge and derives every expected value from its depth-two and depth-three entries. All outputs are compared at the falling edge, after the design has settled. One scenario lines a read up with the edge that sets a new flag, to show that the flag is kept.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int DW      = 8;
    localparam int AW      = 2;
    localparam int NLINES  = 4;
    localparam int CTRL_W  = 5;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_STAT = 2'd1;
    localparam logic [AW-1:0] A_IEN  = 2'd2;

    // line index inside the modem vector; order fixes status bit positions
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    localparam int C_GPO1 = 2;
    localparam int C_GPO2 = 3;
    localparam int C_LOOP = 4;
    localparam int IE_BIT = 3;

    // lines whose flag captures only the low-to-high pin transition
    localparam logic [NLINES-1:0] RISE_ONLY = 4'b0100;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              ien;
    } regs_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '1;
                else     stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int              N    = 4,
    parameter logic [N-1:0]    RISE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic         clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flg;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] evt;

    generate
        for (genvar g = 0; g < N; g++) begin : g_evt
            if (RISE[g]) begin : g_rise
                assign evt[g] = lvl[g] & ~st_q.prev[g];
            end else begin : g_any
                assign evt[g] = lvl[g] ^ st_q.prev[g];
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.flg  = (clr ? '0 : st_q.flg) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prev <= '1;
            st_q.flg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flg;

    p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && (lvl == st_q.prev)) |=> (flags == '0));

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            if (RISE[g]) begin : g_rchk
                p_trail_edge_r5: assert property (@(posedge clk) disable iff (rst)
                    $rose(flags[g]) |-> ($past(lvl[g]) && !$past(st_q.prev[g])));
            end else begin : g_achk
                p_any_change_r6: assert property (@(posedge clk) disable iff (rst)
                    $rose(flags[g]) |-> ($past(lvl[g]) != $past(st_q.prev[g])));
            end
        end
    endgenerate
endmodule

// File: rtl/mdm_ctrl_stat.sv
module mdm_ctrl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cts_n,
    input  logic          dsr_n,
    input  logic          ri_n,
    input  logic          dcd_n,
    output logic          gpo1_n,
    output logic          gpo2_n,
    output logic          loop_mode,
    output logic          modem_irq
);
    regs_t             r_d, r_q;
    logic [NLINES-1:0] pins, lvl, flags;
    logic              stat_rd;

    assign pins = {dcd_n, ri_n, dsr_n, cts_n};

    mdm_sync #(.N(NLINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins),
        .dout (lvl)
    );

    assign stat_rd = rd_en && (addr == A_STAT);

    mdm_delta #(.N(NLINES), .RISE(RISE_ONLY)) i_delta (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .clr   (stat_rd),
        .flags (flags)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == A_CTRL) r_d.ctrl = wdata[CTRL_W-1:0];
        if (wr_en && addr == A_IEN)  r_d.ien  = wdata[IE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[CTRL_W-1:0] = r_q.ctrl;
            A_STAT:  rdata = {~lvl, flags};
            A_IEN:   rdata[IE_BIT] = r_q.ien;
            default: rdata = '0;
        endcase
    end

    assign loop_mode = r_q.ctrl[C_LOOP];
    assign gpo1_n    = ~(r_q.ctrl[C_GPO1] & ~r_q.ctrl[C_LOOP]);
    assign gpo2_n    = ~(r_q.ctrl[C_GPO2] & ~r_q.ctrl[C_LOOP]);
    assign modem_irq = r_q.ien & (|flags);

    p_loop_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wdata[C_LOOP]) |=> (gpo1_n && gpo2_n && loop_mode));

    p_gpo_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wdata[C_GPO1] && !wdata[C_LOOP]) |=> !gpo1_n);

    p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_IEN && !wdata[IE_BIT]) |=> !modem_irq);
endmodule

// File: tb/test_mdm_ctrl_stat.sv
module test_mdm_ctrl_stat;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       gpo1_n, gpo2_n, loop_mode, modem_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mdm_ctrl_stat i_mdm_ctrl_stat (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n), .gpo1_n(gpo1_n), .gpo2_n(gpo2_n),
        .loop_mode(loop_mode), .modem_irq(modem_irq)
    );

    // reference model
    logic [3:0] hist[$];
    int  m_ctrl = 0, m_ien = 0, m_flags = 0;

    function automatic int m_read(input int a);
        int lv;
        lv = hist.size() > 1 ? int'(hist[1]) : 15;
        case (a)
            0: return m_ctrl;
            1: return ((~lv & 15) << 4) | m_flags;
            2: return m_ien << 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int ev;
        if (rst) begin
            hist = {4'hF, 4'hF, 4'hF, 4'hF};
            m_ctrl = 0; m_ien = 0; m_flags = 0;
        end else begin
            hist.push_front({dcd_n, ri_n, dsr_n, cts_n});
            if (hist.size() > 4) void'(hist.pop_back());
            ev = 0;
            for (int i = 0; i < 4; i++) begin
                if (i == 2) begin
                    if (!hist[3][i] && hist[2][i]) ev |= (1 << i);
                end else if (hist[3][i] != hist[2][i]) ev |= (1 << i);
            end
            if (rd_en && addr == 2'd1) m_flags = 0;
            m_flags |= ev;
            if (wr_en && addr == 2'd0) m_ctrl = wdata & 8'h1F;
            if (wr_en && addr == 2'd2) m_ien = wdata[3];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int loop_m, g1, g2;
            loop_m = (m_ctrl >> 4) & 1;
            g1 = (((m_ctrl >> 2) & 1) && !loop_m) ? 0 : 1;
            g2 = (((m_ctrl >> 3) & 1) && !loop_m) ? 0 : 1;
            chk("R2/R3 gpo1_n", int'(gpo1_n), g1);
            chk("R2/R3 gpo2_n", int'(gpo2_n), g2);
            chk("R3 loop_mode", int'(loop_mode), loop_m);
            chk("R7 modem_irq", int'(modem_irq), (m_ien && m_flags != 0) ? 1 : 0);
            chk("R2/R4/R5/R6/R7/R8/R9 rdata", int'(rdata), m_read(int'(addr)));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_stat();
        addr = 2'd1; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 gpo1_n", int'(gpo1_n), 1);
        chk("R1 gpo2_n", int'(gpo2_n), 1);
        chk("R1 irq", int'(modem_irq), 0);
        addr = 2'd1; #1 chk("R1 status", int'(rdata), 0);
        addr = 2'd0; #1 chk("R1 ctrl", int'(rdata), 0);
        @(negedge clk);

        // R2 control outputs
        wr(2'd0, 8'hE4);
        chk("R2 gpo1 active", int'(gpo1_n), 0);
        chk("R2 ctrl readback", int'(rdata), 8'h04);
        wr(2'd0, 8'h0C);
        chk("R2 gpo2 active", int'(gpo2_n), 0);
        // R3 loop mode
        wr(2'd0, 8'h1C);
        chk("R3 gpo held high", int'({gpo1_n, gpo2_n, loop_mode}), 3'b111);
        wr(2'd0, 8'h00);

        // R4/R6 carrier detect change
        addr = 2'd1;
        dcd_n = 1'b0;
        idle(1);
        chk("R4 not yet visible", int'(rdata[7]), 0);
        idle(1);
        chk("R4 present dcd", int'(rdata[7]), 1);
        chk("R6 flag not yet", int'(rdata[3]), 0);
        idle(1);
        chk("R6 dcd delta", int'(rdata[3]), 1);
        rd_stat();
        chk("R8 cleared by read", int'(rdata[3:0]), 0);
        dcd_n = 1'b1; idle(4); rd_stat();

        // R5 ring indicator trailing edge
        ri_n = 1'b0; idle(5);
        chk("R5 no flag on falling", int'(rdata[2]), 0);
        chk("R4 ring present", int'(rdata[6]), 1);
        ri_n = 1'b1; idle(4);
        chk("R5 flag on rising", int'(rdata[2]), 1);

        // R7 interrupt enable
        wr(2'd2, 8'hF7);
        chk("R7 no irq when disabled", int'(modem_irq), 0);
        wr(2'd2, 8'h08);
        chk("R7 irq raised", int'(modem_irq), 1);
        rd_stat();
        chk("R7 irq drops after clear", int'(modem_irq), 0);

        // R9 writes to status and address 3 ignored
        dsr_n = 1'b0; idle(4);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'hFF);
        addr = 2'd1; #1 chk("R9 flag kept after status write", int'(rdata[1]), 1);
        addr = 2'd3; #1 chk("R9 address 3 reads 0", int'(rdata), 0);
        addr = 2'd0; #1 chk("R9 ctrl untouched", int'(rdata), 0);
        @(negedge clk);
        rd_stat();

        // R8 read on the same edge that sets a new flag
        cts_n = 1'b0;
        idle(2);
        rd_stat();
        chk("R8 same-edge flag kept", int'(rdata[0]), 1);
        chk("R6 cts delta", int'(modem_irq), 1);
        rd_stat();
        chk("R8 cleared next read", int'(rdata[3:0]), 0);

        // R6 data-set-ready change back, R1 reset again
        dsr_n = 1'b1; idle(4);
        chk("R6 dsr delta", int'(rdata[1]), 1);
        wr(2'd0, 8'h0C);
        rst = 1'b1; idle(2);
        chk("R1 reset clears outputs", int'({gpo1_n, gpo2_n, modem_irq}), 3'b110);
        rst = 1'b0; idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule